// File: doc/BRIEF.md
# Pixel Raster-Operation Mix Unit

This block takes one pixel per cycle and works out the new value of a destination pixel. It has two mix paths, a foreground path and a background path. Each path picks its own source operand from a choice of inputs and combines it with the destination pixel using its own mix code. A per-pixel monochrome selector bit decides which path's result is used.

The mix codes cover the sixteen two-operand boolean functions of source and destination. One extra code averages source and destination channel by channel. The chosen result is merged with the old destination pixel under a write mask, so only the enabled bits change. The merged pixel is registered and appears one cycle after the input is accepted.

The block is meant to sit inside a drawing engine. Address generation and memory traffic are handled upstream and downstream of it.

Top module: `rop_mix_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released with no input, `out_valid` is 0 and `out_pix` is all zeros.
- R2: When `in_valid` is 1 at a rising clock edge, `out_valid` is 1 after that edge and shows the result for those inputs. When `in_valid` is 0 at an edge, `out_valid` is 0 after it.
- R3: The per-pixel selector comes from `src_ctl[17:16]`: 0 gives a constant 1, 1 gives `pat_bit`, 2 gives `host_bit`, 3 gives `blit_bit`. A selector of 1 uses the foreground path and 0 uses the background path.
- R4: The background source select is `src_ctl[2:0]` and the foreground source select is `src_ctl[10:8]`. The encodings are 0 = `bg_color`, 1 = `fg_color`, 2 = `host_pix`, 3 = `blit_pix`, 4 = `pat_pix`, 5 = `shade_pix`. The values 6 and 7 give an all-zero source.
- R5: The background mix code is `mix_ctl[4:0]` and the foreground mix code is `mix_ctl[20:16]`. With S the source and D the destination, codes 0 to 15 give, in code order: ~D, 0, all-ones, D, ~S, D^S, ~(D^S), S, ~D|~S, D|~S, ~D|S, D|S, D&S, ~D&S, D&~S, ~D&~S.
- R6: Mix code 23 gives floor((D+S)/2) separately in each CH_W-bit channel. No carry passes between channels.
- R7: Mix codes 16 to 22 and 24 to 31 give D, so the destination is left unchanged.
- R8: A bit of `out_pix` whose `wr_mask` bit is 0 equals that bit of `dst_pix`. A bit whose mask bit is 1 takes the mix result.
- R9: When `in_valid` is 0, `out_pix` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel and controls are valid this cycle |
| mix_ctl | input | 32 | Mix codes: background [4:0], foreground [20:16] |
| src_ctl | input | 32 | Source selects: background [2:0], foreground [10:8], selector source [17:16] |
| wr_mask | input | PIX_W | Per-bit write enable for the destination |
| fg_color | input | PIX_W | Foreground colour |
| bg_color | input | PIX_W | Background colour |
| host_pix | input | PIX_W | Host-supplied pixel |
| blit_pix | input | PIX_W | Blit-source pixel |
| pat_pix | input | PIX_W | Pattern pixel |
| shade_pix | input | PIX_W | Pixel from the 3D shading path |
| dst_pix | input | PIX_W | Current destination pixel |
| host_bit | input | 1 | Host monochrome bit |
| blit_bit | input | 1 | Blit monochrome bit |
| pat_bit | input | 1 | Pattern monochrome bit |
| out_valid | output | 1 | Result pixel valid |
| out_pix | output | PIX_W | Registered result pixel |

## Verification
The assertions assume that every input sampled with `in_valid` high is a known value. They also assume the control fields are stable for the whole cycle in which they are sampled, because the masked-bit, unused-code and constant-selector properties compare the output with the inputs from the previous cycle. The stimulus changes inputs only on falling clock edges and always drives full known words. Reset is held for several edges before any valid input is applied. Apart from the bench's hold check, the stimulus keeps `in_valid` high continuously, so every sampled cycle carries defined data.

// File: rtl/rop_mix_pkg.sv
package rop_mix_pkg;

    localparam int CODE_W  = 5;
    localparam int SEL_W   = 3;
    localparam int MONO_W  = 2;

    // field positions inside the control words
    localparam int BG_MIX_LSB  = 0;
    localparam int FG_MIX_LSB  = 16;
    localparam int BG_SRC_LSB  = 0;
    localparam int FG_SRC_LSB  = 8;
    localparam int MONO_LSB    = 16;

    typedef enum logic [SEL_W-1:0] {
        SRC_BG    = 3'd0,
        SRC_FG    = 3'd1,
        SRC_HOST  = 3'd2,
        SRC_BLIT  = 3'd3,
        SRC_PAT   = 3'd4,
        SRC_SHADE = 3'd5
    } src_sel_e;

    typedef enum logic [MONO_W-1:0] {
        MONO_ONE  = 2'd0,
        MONO_PAT  = 2'd1,
        MONO_HOST = 2'd2,
        MONO_BLIT = 2'd3
    } mono_sel_e;

    localparam logic [CODE_W-1:0] MIX_AVERAGE = 5'd23;

    function automatic logic code_is_live(input logic [CODE_W-1:0] code);
        return (code[4] == 1'b0) || (code == MIX_AVERAGE);
    endfunction

endpackage

// File: rtl/rop_src_sel.sv
module rop_src_sel
    import rop_mix_pkg::*;
#(
    parameter int PIX_W = 16
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [PIX_W-1:0] bg_color,
    input  logic [PIX_W-1:0] fg_color,
    input  logic [PIX_W-1:0] host_pix,
    input  logic [PIX_W-1:0] blit_pix,
    input  logic [PIX_W-1:0] pat_pix,
    input  logic [PIX_W-1:0] shade_pix,
    output logic [PIX_W-1:0] src_pix
);

    always_comb begin
        case (sel)
            SRC_BG:    src_pix = bg_color;
            SRC_FG:    src_pix = fg_color;
            SRC_HOST:  src_pix = host_pix;
            SRC_BLIT:  src_pix = blit_pix;
            SRC_PAT:   src_pix = pat_pix;
            SRC_SHADE: src_pix = shade_pix;
            default:   src_pix = '0;
        endcase
    end

endmodule

// File: rtl/rop_mix_core.sv
module rop_mix_core
    import rop_mix_pkg::*;
#(
    parameter int CH_W   = 4,
    parameter int NUM_CH = 4,
    localparam int PIX_W = CH_W * NUM_CH
) (
    input  logic [CODE_W-1:0] code,
    input  logic [PIX_W-1:0]  s,
    input  logic [PIX_W-1:0]  d,
    output logic [PIX_W-1:0]  res
);

    logic [PIX_W-1:0] avg_pix;
    logic [PIX_W-1:0] bool_pix;

    // per-channel truncating average; each channel has its own carry
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic [CH_W:0] sum_c;
        assign sum_c = {1'b0, d[c*CH_W +: CH_W]} + {1'b0, s[c*CH_W +: CH_W]};
        assign avg_pix[c*CH_W +: CH_W] = sum_c[CH_W:1];
    end

    always_comb begin
        case (code[3:0])
            4'd0:    bool_pix = ~d;
            4'd1:    bool_pix = '0;
            4'd2:    bool_pix = '1;
            4'd3:    bool_pix = d;
            4'd4:    bool_pix = ~s;
            4'd5:    bool_pix = d ^ s;
            4'd6:    bool_pix = ~(d ^ s);
            4'd7:    bool_pix = s;
            4'd8:    bool_pix = ~d | ~s;
            4'd9:    bool_pix = d | ~s;
            4'd10:   bool_pix = ~d | s;
            4'd11:   bool_pix = d | s;
            4'd12:   bool_pix = d & s;
            4'd13:   bool_pix = ~d & s;
            4'd14:   bool_pix = d & ~s;
            default: bool_pix = ~d & ~s;
        endcase
    end

    always_comb begin
        if (!code[4])
            res = bool_pix;
        else if (code == MIX_AVERAGE)
            res = avg_pix;
        else
            res = d;
    end

endmodule

// File: rtl/rop_mix_unit.sv
module rop_mix_unit
    import rop_mix_pkg::*;
#(
    parameter int CH_W   = 4,
    parameter int NUM_CH = 4,
    localparam int PIX_W = CH_W * NUM_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      mix_ctl,
    input  logic [31:0]      src_ctl,
    input  logic [PIX_W-1:0] wr_mask,
    input  logic [PIX_W-1:0] fg_color,
    input  logic [PIX_W-1:0] bg_color,
    input  logic [PIX_W-1:0] host_pix,
    input  logic [PIX_W-1:0] blit_pix,
    input  logic [PIX_W-1:0] pat_pix,
    input  logic [PIX_W-1:0] shade_pix,
    input  logic [PIX_W-1:0] dst_pix,
    input  logic             host_bit,
    input  logic             blit_bit,
    input  logic             pat_bit,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);

    localparam int NUM_SIDE = 2;   // index 0 = background, 1 = foreground

    typedef struct packed {
        logic             valid;
        logic [PIX_W-1:0] pix;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [CODE_W-1:0] side_code [NUM_SIDE];
    logic [SEL_W-1:0]  side_sel  [NUM_SIDE];
    logic [PIX_W-1:0]  side_src  [NUM_SIDE];
    logic [PIX_W-1:0]  side_res  [NUM_SIDE];
    logic [MONO_W-1:0] mono_sel;
    logic              mono_bit;
    logic [PIX_W-1:0]  mix_pix;

    assign side_code[0] = mix_ctl[BG_MIX_LSB +: CODE_W];
    assign side_code[1] = mix_ctl[FG_MIX_LSB +: CODE_W];
    assign side_sel[0]  = src_ctl[BG_SRC_LSB +: SEL_W];
    assign side_sel[1]  = src_ctl[FG_SRC_LSB +: SEL_W];
    assign mono_sel     = src_ctl[MONO_LSB +: MONO_W];

    logic unused_ctl_bits;
    assign unused_ctl_bits = ^{mix_ctl[31:21], mix_ctl[15:5],
                               src_ctl[31:18], src_ctl[15:11], src_ctl[7:3]};

    for (genvar g = 0; g < NUM_SIDE; g++) begin : g_side
        rop_src_sel #(.PIX_W(PIX_W)) u_src (
            .sel       (side_sel[g]),
            .bg_color  (bg_color),
            .fg_color  (fg_color),
            .host_pix  (host_pix),
            .blit_pix  (blit_pix),
            .pat_pix   (pat_pix),
            .shade_pix (shade_pix),
            .src_pix   (side_src[g])
        );

        rop_mix_core #(.CH_W(CH_W), .NUM_CH(NUM_CH)) u_mix (
            .code (side_code[g]),
            .s    (side_src[g]),
            .d    (dst_pix),
            .res  (side_res[g])
        );
    end

    always_comb begin
        case (mono_sel)
            MONO_ONE:  mono_bit = 1'b1;
            MONO_PAT:  mono_bit = pat_bit;
            MONO_HOST: mono_bit = host_bit;
            default:   mono_bit = blit_bit;
        endcase
        mix_pix = mono_bit ? side_res[1] : side_res[0];
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid)
            st_d.pix = (mix_pix & wr_mask) | (dst_pix & ~wr_mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_pix   = st_q.pix;

    // ---------------- assertions ----------------
    logic both_dead;
    logic const_one_fg;
    assign both_dead    = !code_is_live(side_code[0]) && !code_is_live(side_code[1]);
    assign const_one_fg = (mono_sel == MONO_ONE) && (side_code[1] == 5'd2);

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && out_valid == out_valid) |=> $stable(out_pix));
    p_masked_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (((out_pix ^ $past(dst_pix)) & ~$past(wr_mask)) == '0));
    p_dead_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && both_dead) |=> (out_pix == $past(dst_pix)));
    p_const_fg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && const_one_fg) |=> (out_pix == ($past(dst_pix) | $past(wr_mask))));

endmodule

// File: tb/tb_rop_mix_unit.sv
module tb_rop_mix_unit;

    localparam int CLK_PERIOD = 10;
    localparam int CH_W   = 4;
    localparam int NUM_CH = 4;
    localparam int PIX_W  = CH_W * NUM_CH;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [31:0]      mix_ctl = '0;
    logic [31:0]      src_ctl = '0;
    logic [PIX_W-1:0] wr_mask = '0;
    logic [PIX_W-1:0] fg_color = '0, bg_color = '0, host_pix = '0, blit_pix = '0;
    logic [PIX_W-1:0] pat_pix = '0, shade_pix = '0, dst_pix = '0;
    logic             host_bit = 1'b0, blit_bit = 1'b0, pat_bit = 1'b0;
    logic             out_valid;
    logic [PIX_W-1:0] out_pix;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rop_mix_unit #(.CH_W(CH_W), .NUM_CH(NUM_CH)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .mix_ctl(mix_ctl), .src_ctl(src_ctl), .wr_mask(wr_mask),
        .fg_color(fg_color), .bg_color(bg_color), .host_pix(host_pix),
        .blit_pix(blit_pix), .pat_pix(pat_pix), .shade_pix(shade_pix),
        .dst_pix(dst_pix), .host_bit(host_bit), .blit_bit(blit_bit),
        .pat_bit(pat_bit), .out_valid(out_valid), .out_pix(out_pix)
    );

    // ---------- reference model from the requirements ----------
    function automatic logic [PIX_W-1:0] ref_mix(input int code,
                                                 input logic [PIX_W-1:0] d,
                                                 input logic [PIX_W-1:0] s);
        logic [PIX_W-1:0] r;
        case (code)
            0:  r = ~d;
            1:  r = '0;
            2:  r = '1;
            3:  r = d;
            4:  r = ~s;
            5:  r = d ^ s;
            6:  r = ~(d ^ s);
            7:  r = s;
            8:  r = ~d | ~s;
            9:  r = d | ~s;
            10: r = ~d | s;
            11: r = d | s;
            12: r = d & s;
            13: r = ~d & s;
            14: r = d & ~s;
            15: r = ~d & ~s;
            23: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    int a = int'(d[c*CH_W +: CH_W]) + int'(s[c*CH_W +: CH_W]);
                    r[c*CH_W +: CH_W] = CH_W'(a / 2);
                end
            end
            default: r = d;
        endcase
        return r;
    endfunction

    function automatic logic [PIX_W-1:0] ref_src(input int sel);
        case (sel)
            0: return bg_color;
            1: return fg_color;
            2: return host_pix;
            3: return blit_pix;
            4: return pat_pix;
            5: return shade_pix;
            default: return '0;
        endcase
    endfunction

    function automatic logic [PIX_W-1:0] ref_pixel();
        logic mb;
        int code, sel;
        case (src_ctl[17:16])
            2'd0: mb = 1'b1;
            2'd1: mb = pat_bit;
            2'd2: mb = host_bit;
            default: mb = blit_bit;
        endcase
        code = mb ? int'(mix_ctl[20:16]) : int'(mix_ctl[4:0]);
        sel  = mb ? int'(src_ctl[10:8]) : int'(src_ctl[2:0]);
        return (ref_mix(code, dst_pix, ref_src(sel)) & wr_mask) | (dst_pix & ~wr_mask);
    endfunction

    function automatic string code_tag(input int code);
        if (code < 16) return "R5";
        if (code == 23) return "R6";
        return "R7";
    endfunction

    task automatic check(input string tag, input logic [PIX_W-1:0] act,
                         input logic [PIX_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // inputs are set at a falling edge; the result is sampled one full cycle later
    task automatic apply(input string tag);
        logic [PIX_W-1:0] exp;
        exp = ref_pixel();
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R2", {15'd0, out_valid}, 16'd1);
        check(tag, out_pix, exp);
    endtask

    task automatic randomize_data();
        fg_color  = PIX_W'($urandom);
        bg_color  = PIX_W'($urandom);
        host_pix  = PIX_W'($urandom);
        blit_pix  = PIX_W'($urandom);
        pat_pix   = PIX_W'($urandom);
        shade_pix = PIX_W'($urandom);
        dst_pix   = PIX_W'($urandom);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        check("R1", {15'd0, out_valid}, 16'd0);
        check("R1", out_pix, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {15'd0, out_valid}, 16'd0);
        check("R1", out_pix, 16'd0);

        // R5 R6 R7 on the foreground path (selector constant one, blit source)
        wr_mask = '1;
        for (int code = 0; code < 32; code++) begin
            for (int rep = 0; rep < 3; rep++) begin
                randomize_data();
                mix_ctl = 32'(code) << 16;
                src_ctl = (32'd3 << 8);
                apply(code_tag(code));
            end
        end

        // same codes on the background path: selector from pattern bit 0, host source
        for (int code = 0; code < 32; code++) begin
            randomize_data();
            pat_bit = 1'b0;
            mix_ctl = 32'(code) | (32'd3 << 16);
            src_ctl = (32'd1 << 16) | 32'd2;
            apply(code_tag(code));
        end

        // R6 channel corners: no carry between channels, truncation
        mix_ctl = 32'd23 << 16;
        src_ctl = 32'd3 << 8;
        dst_pix = 16'hFFFF; blit_pix = 16'hFFFF; apply("R6");
        dst_pix = 16'hF0F0; blit_pix = 16'h1010; apply("R6");
        dst_pix = 16'h8001; blit_pix = 16'h8000; apply("R6");
        check("R6", out_pix, 16'h8000);

        // R4: every source select on each side (mix code S)
        for (int sel = 0; sel < 8; sel++) begin
            randomize_data();
            mix_ctl = 32'd7 << 16;
            src_ctl = 32'(sel) << 8;
            apply("R4");
            randomize_data();
            host_bit = 1'b0;
            mix_ctl = 32'd7;
            src_ctl = (32'd2 << 16) | 32'(sel);
            apply("R4");
        end

        // R3: selector sources against every bit combination (fg=ONE, bg=ZERO)
        for (int ms = 0; ms < 4; ms++) begin
            for (int bits = 0; bits < 8; bits++) begin
                randomize_data();
                pat_bit  = bits[0];
                host_bit = bits[1];
                blit_bit = bits[2];
                mix_ctl  = (32'd2 << 16) | 32'd1;
                src_ctl  = 32'(ms) << 16;
                apply("R3");
            end
        end

        // R8: write mask patterns with XOR mix
        for (int m = 0; m < 12; m++) begin
            randomize_data();
            wr_mask = (m == 0) ? '0 : (m == 1) ? 16'h00FF : PIX_W'($urandom);
            mix_ctl = 32'd5 << 16;
            src_ctl = 32'd1 << 8;
            apply("R8");
        end

        // R9 and R2: idle cycles keep the last pixel and drop valid
        begin
            logic [PIX_W-1:0] last;
            last = out_pix;
            in_valid = 1'b0;
            randomize_data();
            wr_mask = '1;
            mix_ctl = 32'd2 << 16;
            @(posedge clk);
            @(negedge clk);
            check("R2", {15'd0, out_valid}, 16'd0);
            randomize_data();
            @(negedge clk);
            check("R9", out_pix, last);
            check("R2", {15'd0, out_valid}, 16'd0);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule